// File: doc/BRIEF.md
# Bring-up Bus Responder for a 16-bit Asynchronous Processor Bus

This block lets a bare 16-bit processor run with no memory attached, so that its clocking and strobe behaviour can be studied on its own. After system reset it holds the processor's halt and reset lines low for a fixed time, then lets go of both at once. After that it answers every bus cycle the processor starts. The processor's address strobe and its two byte-lane data strobes are asynchronous to the system clock, so they are first resynchronised. The acknowledge is then asserted after a short, parameterised delay. It stays low until the address strobe is taken away, which gives a fully interlocked handshake.

The data bus always carries one constant word. By default this is 0x60FE, a short branch whose displacement of -2 points back at itself. The stack-pointer and program-counter fetches that follow reset therefore complete, and the processor then spins on that one opcode. A status side keeps three results. It counts completed handshakes in a saturating counter. It keeps a sticky flag for any cycle in which neither data strobe was active when it was acknowledged. It raises a stall flag when no new address strobe arrives within a timeout.

Top module: `cbr_bus_responder`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `halt_n` and `cpu_reset_n` are 0, `dtack_n` is 1, `cycle_count` is 0, and `strobe_err` and `stall` are 0.
- R2: After `rst` falls, `halt_n` and `cpu_reset_n` stay 0 through rising edge HOLD_CYCLES-1. Both become 1 on rising edge HOLD_CYCLES, which is the same edge for both, and they stay 1 until the next `rst`.
- R3: While the processor is held, strobe activity is ignored. `dtack_n` stays 1 and `cycle_count` stays 0.
- R4: With `as_n` held low, `dtack_n` goes to 0 on the (3+ACK_DELAY)-th rising edge after `as_n` falls. This is 5 edges with ACK_DELAY = 2, and it is never earlier.
- R5: `dtack_n` stays 0 for as long as `as_n` stays low. It returns to 1 on the 3rd rising edge after `as_n` rises.
- R6: `data_out` always equals the parameter WORD, which is 0x60FE by default.
- R7: `cycle_count` rises by exactly 1 per completed handshake, visible 4 edges after `as_n` rises. A strobe removed before acknowledge is given produces no acknowledge and no count.
- R8: `cycle_count` saturates at all ones, which is 15 when CNT_W = 4, and stays there.
- R9: If both `uds_n` and `lds_n` are 1 at the moment acknowledge is given, `strobe_err` sets and stays 1 until `rst`. Such a cycle is still acknowledged and counted.
- R10: After release, `stall` becomes 1 on the (STALL_CYCLES+2)-th edge after `as_n` rises with no new strobe. It clears on the 3rd edge after `as_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Processor address strobe, active low, asynchronous |
| uds_n | input | 1 | Upper byte data strobe, active low, asynchronous |
| lds_n | input | 1 | Lower byte data strobe, active low, asynchronous |
| halt_n | output | 1 | Processor halt, active low |
| cpu_reset_n | output | 1 | Processor reset, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| data_out | output | 16 | Constant word driven on the data bus |
| cycle_count | output | CNT_W | Saturating count of completed handshakes |
| strobe_err | output | 1 | Sticky flag: a cycle was acknowledged with no data strobe |
| stall | output | 1 | No address strobe within STALL_CYCLES |

## Verification
The handshake is driven through every combination of the two data strobes, and each combination is repeated with several strobe hold lengths. The strobe-hold sweep separates a truly interlocked acknowledge from one that times out. The strobe combinations separate the normal cycle from the no-strobe cycle that must set the error flag. A strobe pulse cut short before acknowledge tells whether the block counts only completed handshakes. Strobe activity during the reset hold shows that the block stays quiet until release. A long idle gap followed by a new strobe checks both edges of the stall flag.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_t;
endpackage

// File: rtl/cbr_sync.sv
// Two-stage synchroniser for active-low strobes; resets to the inactive level.
module cbr_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= 1'b1;
          s2 <= 1'b1;
        end else begin
          s1 <= d_in[i];
          s2 <= s1;
        end
      end
      assign q_out[i] = s2;
    end
  endgenerate
endmodule

// File: rtl/cbr_reset_seq.sv
// Holds the processor in halt+reset for HOLD_CYCLES, then releases both.
module cbr_reset_seq #(
  parameter int HOLD_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic released
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] hold_cnt;
  logic          rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      rel_q    <= 1'b0;
    end else if (!rel_q) begin
      if (hold_cnt == CW'(HOLD_CYCLES - 1)) rel_q <= 1'b1;
      else                                   hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign released = rel_q;

  AST_STAYS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    rel_q |=> rel_q); // R2
endmodule

// File: rtl/cbr_handshake.sv
// Interlocked acknowledge engine working on synchronised strobes.
module cbr_handshake
  import cbr_pkg::*;
#(
  parameter int ACK_DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic as_act,
  input  logic uds_act,
  input  logic lds_act,
  output logic dtack_n,
  output logic cyc_done,
  output logic no_strobe
);
  localparam int DW = $clog2(ACK_DELAY + 1);

  hs_state_t     st;
  logic [DW-1:0] dly;
  logic          dtack_q, done_q, nods_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= HS_IDLE;
      dly     <= '0;
      dtack_q <= 1'b1;
      done_q  <= 1'b0;
      nods_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      nods_q <= 1'b0;
      case (st)
        HS_IDLE: begin
          if (enable && as_act) begin
            st  <= HS_WAIT;
            dly <= DW'(1);
          end
        end
        HS_WAIT: begin
          if (!as_act) begin
            st <= HS_IDLE;
          end else if (dly == DW'(ACK_DELAY)) begin
            st      <= HS_ACK;
            dtack_q <= 1'b0;
            nods_q  <= !uds_act && !lds_act;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        HS_ACK: begin
          if (!as_act) begin
            st      <= HS_IDLE;
            dtack_q <= 1'b1;
            done_q  <= 1'b1;
          end
        end
        default: st <= HS_IDLE;
      endcase
    end
  end

  assign dtack_n   = dtack_q;
  assign cyc_done  = done_q;
  assign no_strobe = nods_q;

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && as_act) |=> !dtack_n); // R5
  AST_ACK_LATE: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_n) |-> ($past(as_act, 1) && $past(as_act, 2))); // R4
endmodule

// File: rtl/cbr_monitor.sv
// Saturating cycle counter, sticky strobe error and stall timer.
module cbr_monitor #(
  parameter int CNT_W        = 16,
  parameter int STALL_CYCLES = 1_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             as_act,
  input  logic             cyc_done,
  input  logic             no_strobe,
  output logic [CNT_W-1:0] count,
  output logic             err,
  output logic             stall
);
  localparam int SW = $clog2(STALL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             err_q, stall_q;
  logic [SW-1:0]    tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (cyc_done && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (no_strobe) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable || as_act) begin
      tmr     <= '0;
      stall_q <= 1'b0;
    end else if (tmr == SW'(STALL_CYCLES - 1)) begin
      stall_q <= 1'b1;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  assign count = cnt_q;
  assign err   = err_q;
  assign stall = stall_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R8
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cyc_done |=> $stable(cnt_q)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R9
  AST_STALL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    as_act |=> !stall_q); // R10
endmodule

// File: rtl/cbr_bus_responder.sv
module cbr_bus_responder #(
  parameter int          HOLD_CYCLES  = 25_000_000,
  parameter int          ACK_DELAY    = 2,
  parameter int          STALL_CYCLES = 1_000_000,
  parameter int          CNT_W        = 16,
  parameter logic [15:0] WORD         = 16'h60FE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             as_n,
  input  logic             uds_n,
  input  logic             lds_n,
  output logic             halt_n,
  output logic             cpu_reset_n,
  output logic             dtack_n,
  output logic [15:0]      data_out,
  output logic [CNT_W-1:0] cycle_count,
  output logic             strobe_err,
  output logic             stall
);
  logic [2:0]  strb_s;
  logic        released;
  logic        cyc_done, no_strobe;
  logic [15:0] data_q;

  cbr_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({as_n, uds_n, lds_n}),
    .q_out(strb_s)
  );

  cbr_reset_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_rseq (
    .clk     (clk),
    .rst     (rst),
    .released(released)
  );

  cbr_handshake #(.ACK_DELAY(ACK_DELAY)) u_hs (
    .clk      (clk),
    .rst      (rst),
    .enable   (released),
    .as_act   (!strb_s[2]),
    .uds_act  (!strb_s[1]),
    .lds_act  (!strb_s[0]),
    .dtack_n  (dtack_n),
    .cyc_done (cyc_done),
    .no_strobe(no_strobe)
  );

  cbr_monitor #(.CNT_W(CNT_W), .STALL_CYCLES(STALL_CYCLES)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .enable   (released),
    .as_act   (!strb_s[2]),
    .cyc_done (cyc_done),
    .no_strobe(no_strobe),
    .count    (cycle_count),
    .err      (strobe_err),
    .stall    (stall)
  );

  always_ff @(posedge clk) data_q <= WORD;

  assign halt_n      = released;
  assign cpu_reset_n = released;
  assign data_out    = data_q;

  AST_QUIET_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !released |-> dtack_n); // R3
  AST_NO_COUNT_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !released |-> (cycle_count == '0)); // R3
endmodule

// File: tb/cbr_bus_responder_tb_top.sv
module cbr_bus_responder_tb_top;
  localparam int HOLD  = 20;
  localparam int AD    = 2;
  localparam int STALL = 40;
  localparam int CW    = 4;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
  logic halt_n, cpu_reset_n, dtack_n, strobe_err, stall;
  logic [15:0]   data_out;
  logic [CW-1:0] cycle_count;

  int  n_run = 0, n_fail = 0, exp_cnt = 0;
  bit  exp_err = 1'b0, finished = 1'b0;

  always #5 clk = ~clk;

  cbr_bus_responder #(
    .HOLD_CYCLES(HOLD), .ACK_DELAY(AD), .STALL_CYCLES(STALL), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .halt_n(halt_n), .cpu_reset_n(cpu_reset_n), .dtack_n(dtack_n),
    .data_out(data_out), .cycle_count(cycle_count),
    .strobe_err(strobe_err), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_cycle(input bit u, input bit l, input int hold);
    as_n = 1'b0; uds_n = u; lds_n = l;
    tick(3 + AD - 1);
    chk(dtack_n == 1'b1, "R4", "ack not early", dtack_n, 1);
    tick(1);
    chk(dtack_n == 1'b0, "R4", "ack on time", dtack_n, 0);
    chk(data_out == 16'h60FE, "R6", "data word", data_out, 16'h60FE);
    for (int i = 0; i < hold; i++) begin
      tick(1);
      chk(dtack_n == 1'b0, "R5", "ack held", dtack_n, 0);
    end
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    tick(2);
    chk(dtack_n == 1'b0, "R5", "ack before release", dtack_n, 0);
    tick(1);
    chk(dtack_n == 1'b1, "R5", "ack released", dtack_n, 1);
    if (u && l) exp_err = 1'b1;
    exp_cnt = (exp_cnt < CMAX) ? exp_cnt + 1 : CMAX;
    tick(1);
    chk(int'(cycle_count) == exp_cnt, (exp_cnt == CMAX) ? "R8" : "R7",
        "count", cycle_count, exp_cnt);
    chk(strobe_err == exp_err, "R9", "strobe error", strobe_err, exp_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    chk(halt_n == 1'b0 && cpu_reset_n == 1'b0, "R1", "held", {halt_n, cpu_reset_n}, 0);
    chk(dtack_n == 1'b1, "R1", "dtack idle", dtack_n, 1);
    chk(cycle_count == '0 && !strobe_err && !stall, "R1", "status",
        {cycle_count, strobe_err, stall}, 0);
    chk(data_out == 16'h60FE, "R6", "data in reset", data_out, 16'h60FE);
    rst = 1'b0;
    for (int k = 1; k <= HOLD; k++) begin
      tick(1);
      if (k == 2) begin as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0; end
      if (k == 6) begin as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; end
      if (k < HOLD) chk(dtack_n == 1'b1, "R3", "no ack in hold", dtack_n, 1);
      if (k == HOLD - 1)
        chk(halt_n == 1'b0 && cpu_reset_n == 1'b0, "R2", "still held",
            {halt_n, cpu_reset_n}, 0);
      if (k == HOLD)
        chk(halt_n == 1'b1 && cpu_reset_n == 1'b1, "R2", "released together",
            {halt_n, cpu_reset_n}, 3);
    end
    chk(cycle_count == '0, "R3", "no count in hold", cycle_count, 0);
    tick(3);

    // R7 aborted strobe: no ack, no count
    as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
    tick(2);
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk(dtack_n == 1'b1, "R7", "no ack on abort", dtack_n, 1);
    end
    chk(cycle_count == '0, "R7", "no count on abort", cycle_count, 0);

    // sweep: hold lengths x strobe combinations (uds_n=ds[1], lds_n=ds[0])
    for (int h = 0; h < 5; h++)
      for (int ds = 0; ds < 4; ds++)
        bus_cycle(ds[1], ds[0], h);

    // R10 stall: 4 ticks already since as_n rose
    tick(STALL + 1 - 4);
    chk(stall == 1'b0, "R10", "stall not early", stall, 0);
    tick(1);
    chk(stall == 1'b1, "R10", "stall raised", stall, 1);
    as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
    tick(2);
    chk(stall == 1'b1, "R10", "stall before sync", stall, 1);
    tick(1);
    chk(stall == 1'b0, "R10", "stall cleared", stall, 0);
    tick(2);
    chk(dtack_n == 1'b0, "R4", "ack after stall", dtack_n, 0);
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    tick(4);
    chk(int'(cycle_count) == CMAX, "R8", "saturated", cycle_count, CMAX);
    chk(strobe_err == 1'b1, "R9", "error sticky", strobe_err, 1);

    rst = 1'b1;
    tick(2);
    chk(strobe_err == 1'b0 && cycle_count == '0, "R1", "cleared by reset",
        {cycle_count, strobe_err}, 0);
    chk(halt_n == 1'b0, "R1", "held again", halt_n, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule